// File: doc/BRIEF.md
# Edge Interrupt Soft-Mask Replay Controller

This block manages the flow of a single edge-type interrupt line between the interrupt source and the handler. It receives each edge strobe and decides what to do with it. If the line is free, it acknowledges the source and requests a handler run. If a handler is already running, it records the edge as pending. If the line is disabled or has no handler, it records the edge and masks the source. Edges that arrive while the line is busy or disabled are therefore kept and run later, not lost.

When the handler reports completion, the controller starts another run straight away if a pending edge is waiting and the line is enabled. Otherwise it returns the line to idle. When software re-enables a line that holds a pending edge, the controller unmasks the source and issues one replay request. A wrapping counter records every handler request.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `irq_soft_mask_ctrl`

## Requirements
- R1: The replay and waiting flags are both cleared in the cycle after any edge strobe. The waiting flag is set out of reset and by each accepted enable command, and an edge in the same cycle as an enable still clears it.
- R2: An edge seen while the line is disabled (after this cycle's commands) or while no handler is present sets pending and masked. The edge is acknowledged, and no dispatch is issued.
- R3: An edge seen while a handler is busy, with handler present and the line enabled, sets pending and is acknowledged. No second dispatch is started.
- R4: Any other edge is acknowledged, sets busy and issues a dispatch pulse, all in the next cycle.
- R5: Pending reads 0 in every cycle in which dispatch is asserted.
- R6: A done strobe while busy, with handler present, issues another dispatch if pending is set and the line is enabled. Otherwise it clears busy. A done strobe while not busy has no effect.
- R7: A done strobe while busy with no handler present sets masked and clears busy, with no dispatch.
- R8: A disable command sets the disabled flag and an enable command clears it. When both arrive in the same cycle, disable wins and the enable is ignored.
- R9: An accepted enable with the handler present clears masked. If pending is then set and the line is not busy, one replay dispatch is issued: pending clears, busy and replay set.
- R10: The event counter (CNT_W bits, default 8) increments by one on every dispatch pulse and wraps to 0 after its maximum.
- R11: After reset, all status flags and pulses are 0 except waiting, which is 1, and the counter is 0.
- R12: An edge and a done strobe in the same cycle while busy, with handler present and the line enabled, give exactly one dispatch, with pending clear and busy still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_i | input | 1 | Edge strobe from the interrupt source |
| handler_ok_i | input | 1 | A handler is attached to the line |
| disable_cmd_i | input | 1 | Software disable command strobe |
| enable_cmd_i | input | 1 | Software enable command strobe |
| done_i | input | 1 | Handler completion strobe |
| dispatch_o | output | 1 | Handler run request pulse |
| ack_o | output | 1 | Acknowledge pulse to the source |
| mask_o | output | 1 | Mask level to the source (also the masked status) |
| st_disabled_o | output | 1 | Line disabled status |
| st_busy_o | output | 1 | Handler in progress status |
| st_pending_o | output | 1 | Pending edge status |
| st_replay_o | output | 1 | Last dispatch was a replay |
| st_waiting_o | output | 1 | Armed, no edge seen since reset or enable |
| evt_count_o | output | CNT_W | Wrapping dispatch counter |

## Verification
The key collision is an edge strobe and a handler-done strobe in the same cycle while the line is busy. The new edge must be picked up by the re-run loop, not lost and not dispatched twice. A directed sequence produces this collision and checks for a single dispatch with pending clear and busy kept. Long random stimulus also drives edges, done strobes and enable/disable commands together, including an enable arriving with an edge or a done. A behavioural model in the bench judges every cycle.

// File: rtl/irq_flow_pkg.sv
package irq_flow_pkg;

    typedef struct packed {
        logic disabled;
        logic busy;
        logic pending;
        logic masked;
        logic replay;
        logic waiting;
    } line_state_t;

    typedef struct packed {
        logic dispatch;
        logic ack;
    } line_pulse_t;

    typedef enum logic [1:0] {
        EDGE_NONE,
        EDGE_PARK,
        EDGE_HOLD,
        EDGE_RUN
    } edge_class_t;

    localparam line_state_t LINE_RESET = '{
        disabled: 1'b0, busy: 1'b0, pending: 1'b0,
        masked: 1'b0, replay: 1'b0, waiting: 1'b1
    };

    function automatic edge_class_t classify_edge(
        input logic seen, input logic off, input logic have_handler, input logic running);
        if (!seen)                     return EDGE_NONE;
        else if (off || !have_handler) return EDGE_PARK;
        else if (running)              return EDGE_HOLD;
        else                           return EDGE_RUN;
    endfunction

endpackage

// File: rtl/irq_edge_classifier.sv
module irq_edge_classifier
    import irq_flow_pkg::*;
(
    input  logic        edge_seen,
    input  logic        line_off,
    input  logic        have_handler,
    input  logic        running,
    output edge_class_t kind
);
    always_comb kind = classify_edge(edge_seen, line_off, have_handler, running);
endmodule

// File: rtl/irq_flow_next.sv
module irq_flow_next
    import irq_flow_pkg::*;
(
    input  line_state_t cur,
    input  logic        edge_seen,
    input  logic        have_handler,
    input  logic        dis_cmd,
    input  logic        en_cmd,
    input  logic        done,
    output line_state_t nxt,
    output line_pulse_t pulse
);
    line_state_t after_cmd;
    edge_class_t kind;
    logic        en_taken;

    assign en_taken = en_cmd && !dis_cmd;

    always_comb begin
        after_cmd = cur;
        if (dis_cmd) begin
            after_cmd.disabled = 1'b1;
        end else if (en_cmd) begin
            after_cmd.disabled = 1'b0;
            after_cmd.waiting  = 1'b1;
            if (have_handler) after_cmd.masked = 1'b0;
        end
    end

    irq_edge_classifier u_classify (
        .edge_seen    (edge_seen),
        .line_off     (after_cmd.disabled),
        .have_handler (have_handler),
        .running      (cur.busy),
        .kind         (kind)
    );

    always_comb begin
        nxt   = after_cmd;
        pulse = '0;
        if (edge_seen) begin
            nxt.replay  = 1'b0;
            nxt.waiting = 1'b0;
        end
        unique case (kind)
            EDGE_PARK: begin
                nxt.pending = 1'b1;
                nxt.masked  = 1'b1;
                pulse.ack   = 1'b1;
            end
            EDGE_HOLD: begin
                nxt.pending = 1'b1;
                pulse.ack   = 1'b1;
            end
            EDGE_RUN: begin
                nxt.busy       = 1'b1;
                nxt.pending    = 1'b0;
                pulse.ack      = 1'b1;
                pulse.dispatch = 1'b1;
            end
            default: ;
        endcase
        if (done && cur.busy) begin
            if (!have_handler) begin
                nxt.masked = 1'b1;
                nxt.busy   = 1'b0;
            end else if (nxt.pending && !nxt.disabled) begin
                nxt.pending    = 1'b0;
                pulse.dispatch = 1'b1;
            end else begin
                nxt.busy = 1'b0;
            end
        end
        if (en_taken && have_handler && nxt.pending && !nxt.busy && !pulse.dispatch) begin
            nxt.pending    = 1'b0;
            nxt.busy       = 1'b1;
            nxt.replay     = 1'b1;
            nxt.masked     = 1'b0;
            pulse.dispatch = 1'b1;
        end
    end
endmodule

// File: rtl/irq_event_counter.sv
module irq_event_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (bump) value <= value + ONE;
    end
endmodule

// File: rtl/irq_soft_mask_ctrl.sv
module irq_soft_mask_ctrl
    import irq_flow_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic             handler_ok_i,
    input  logic             disable_cmd_i,
    input  logic             enable_cmd_i,
    input  logic             done_i,
    output logic             dispatch_o,
    output logic             ack_o,
    output logic             mask_o,
    output logic             st_disabled_o,
    output logic             st_busy_o,
    output logic             st_pending_o,
    output logic             st_replay_o,
    output logic             st_waiting_o,
    output logic [CNT_W-1:0] evt_count_o
);
    line_state_t st_q, st_d;
    line_pulse_t pl_q, pl_d;

    irq_flow_next u_next (
        .cur          (st_q),
        .edge_seen    (edge_i),
        .have_handler (handler_ok_i),
        .dis_cmd      (disable_cmd_i),
        .en_cmd       (enable_cmd_i),
        .done         (done_i),
        .nxt          (st_d),
        .pulse        (pl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LINE_RESET;
            pl_q <= '0;
        end else begin
            st_q <= st_d;
            pl_q <= pl_d;
        end
    end

    irq_event_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .bump  (pl_d.dispatch),
        .value (evt_count_o)
    );

    assign dispatch_o    = pl_q.dispatch;
    assign ack_o         = pl_q.ack;
    assign mask_o        = st_q.masked;
    assign st_disabled_o = st_q.disabled;
    assign st_busy_o     = st_q.busy;
    assign st_pending_o  = st_q.pending;
    assign st_replay_o   = st_q.replay;
    assign st_waiting_o  = st_q.waiting;

    // R5
    dispatch_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
        dispatch_o |-> (!st_pending_o && st_busy_o));

    // R1
    edge_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
        edge_i |=> (!st_replay_o && !st_waiting_o));

    // R2
    parked_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_i && st_disabled_o && !enable_cmd_i) |=>
        (mask_o && ack_o && st_pending_o && !dispatch_o));

    // R3
    busy_edge_held_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_i && st_busy_o && !done_i) |=> (ack_o && st_pending_o && !dispatch_o));

    // R7
    done_no_handler_chk: assert property (@(posedge clk) disable iff (rst)
        (st_busy_o && done_i && !handler_ok_i) |=> (mask_o && !st_busy_o && !dispatch_o));

    // R6
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_busy_o && done_i && !edge_i && !enable_cmd_i) |=> !dispatch_o);

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        dispatch_o |-> (evt_count_o == CNT_W'($past(evt_count_o) + 1)));
endmodule

// File: tb/test_irq_soft_mask_ctrl.sv
module test_irq_soft_mask_ctrl;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic edge_i = 0, handler_ok_i = 1, disable_cmd_i = 0, enable_cmd_i = 0, done_i = 0;
    logic dispatch_o, ack_o, mask_o, st_disabled_o, st_busy_o, st_pending_o;
    logic st_replay_o, st_waiting_o;
    logic [CNT_W-1:0] evt_count_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_off, m_run, m_pend, m_mask, m_rep, m_wait, m_disp, m_ack;
    int m_cnt;

    always #4 clk = ~clk;

    irq_soft_mask_ctrl #(.CNT_W(CNT_W)) i_irq_soft_mask_ctrl (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_off = 0; m_run = 0; m_pend = 0; m_mask = 0; m_rep = 0; m_wait = 1;
        m_disp = 0; m_ack = 0; m_cnt = 0;
    endtask

    task automatic model_step(input bit e, input bit h, input bit dc, input bit ec, input bit dn);
        bit was_run = m_run;
        bit enable_ok = ec && !dc;
        m_disp = 0; m_ack = 0;
        if (dc) m_off = 1;
        if (enable_ok) begin
            m_off = 0; m_wait = 1;
            if (h) m_mask = 0;
        end
        if (e) begin
            m_rep = 0; m_wait = 0; m_ack = 1;
            if (m_off || !h) begin m_pend = 1; m_mask = 1; end
            else if (was_run) m_pend = 1;
            else begin m_run = 1; m_pend = 0; m_disp = 1; end
        end
        if (dn && was_run) begin
            if (!h) begin m_mask = 1; m_run = 0; end
            else if (m_pend && !m_off) begin m_pend = 0; m_disp = 1; end
            else m_run = 0;
        end
        if (enable_ok && h && m_pend && !m_run) begin
            m_pend = 0; m_run = 1; m_rep = 1; m_mask = 0; m_disp = 1;
        end
        if (m_disp) m_cnt = (m_cnt + 1) % (1 << CNT_W);
    endtask

    task automatic compare_all();
        chk("R4 dispatch", dispatch_o, m_disp);
        chk("R2 ack", ack_o, m_ack);
        chk("R7 mask", mask_o, m_mask);
        chk("R5 pending", st_pending_o, m_pend);
        chk("R6 busy", st_busy_o, m_run);
        chk("R8 disabled", st_disabled_o, m_off);
        chk("R9 replay", st_replay_o, m_rep);
        chk("R1 waiting", st_waiting_o, m_wait);
        chk("R10 count", evt_count_o, m_cnt);
    endtask

    task automatic step(input bit e, input bit h, input bit dc, input bit ec, input bit dn);
        edge_i = e; handler_ok_i = h; disable_cmd_i = dc; enable_cmd_i = ec; done_i = dn;
        @(posedge clk);
        model_step(e, h, dc, ec, dn);
        #2;
        compare_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        model_reset();
        #2;
        // R11 reset state
        chk("R11 waiting after reset", st_waiting_o, 1);
        chk("R11 busy after reset", st_busy_o, 0);
        chk("R11 count after reset", evt_count_o, 0);
        compare_all();

        step(1, 1, 0, 0, 0);                       // R4 plain dispatch
        chk("R4 dispatch on idle edge", dispatch_o, 1);
        step(1, 1, 0, 0, 0);                       // R3 edge while busy
        chk("R3 no second dispatch", dispatch_o, 0);
        chk("R3 pending held", st_pending_o, 1);
        step(0, 1, 0, 0, 1);                       // R6 rerun loop
        chk("R6 rerun dispatch", dispatch_o, 1);
        step(0, 1, 0, 0, 1);
        chk("R6 busy cleared", st_busy_o, 0);
        step(0, 1, 0, 0, 1);                       // R6 idle done ignored
        chk("R6 idle done no dispatch", dispatch_o, 0);

        step(1, 1, 0, 0, 0);                       // R12 collision
        step(1, 1, 0, 0, 1);
        chk("R12 single dispatch", dispatch_o, 1);
        chk("R12 pending clear", st_pending_o, 0);
        chk("R12 busy kept", st_busy_o, 1);
        step(0, 1, 0, 0, 1);

        step(0, 1, 1, 0, 0);                       // R2 park while disabled
        step(1, 1, 0, 0, 0);
        chk("R2 masked", mask_o, 1);
        chk("R2 no dispatch", dispatch_o, 0);
        step(0, 1, 1, 1, 0);                       // R8 disable wins
        chk("R8 still disabled", st_disabled_o, 1);
        step(0, 1, 0, 1, 0);                       // R9 replay
        chk("R9 replay dispatch", dispatch_o, 1);
        chk("R9 replay flag", st_replay_o, 1);
        chk("R9 unmasked", mask_o, 0);
        step(1, 1, 0, 0, 0);                       // R1 flags cleared
        chk("R1 replay cleared", st_replay_o, 0);
        step(0, 0, 0, 0, 1);                       // R7 handler gone
        chk("R7 mask on lost handler", mask_o, 1);
        chk("R7 busy cleared", st_busy_o, 0);
        step(0, 1, 0, 1, 0);

        for (int i = 0; i < 300; i++) begin        // R10 wrap
            step(1, 1, 0, 0, 0);
            step(0, 1, 0, 0, 1);
        end

        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 2) == 0, $urandom_range(0, 9) != 0,
                 $urandom_range(0, 11) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 2) == 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule